// File: doc/BRIEF.md
# Multi-Lane Raster Timing Generator

This block produces frame timing for a video pipeline that carries several pixels in each clock. A horizontal counter runs in clock cycles and a vertical counter runs in line-pairs. From the two counters the block derives a data-enable, a horizontal sync and a vertical sync, and it reports the beat index and row-pair index of the current active position so that a downstream packer can select its data. A one-cycle frame-done pulse follows the final active beat of each frame.

Each line is made of four segments in this order: front porch, sync pulse, active, back porch. The vertical axis uses the same order, counted in line periods. The active span is the image width divided by the horizontal lane count, in cycles, and the image height divided by the vertical lane count, in line periods. All segment sizes are parameters. Every output comes from a register on one clock, with an active-low asynchronous reset.

Top module: `mlane_vid_timing`

## Requirements
- R1: While reset is asserted, every output is 0. On the first clock edge after reset is released, the outputs show frame position 0. Each later edge advances the position by one cycle.
- R2: A line lasts H_FP+H_SYNC+WIDTH/H_LANES+H_BP cycles. In each visible line, data-enable is high for exactly WIDTH/H_LANES consecutive cycles, starting at line offset H_FP+H_SYNC.
- R3: A frame lasts the line length times V_FP+V_SYNC+HEIGHT/V_LANES+V_BP line periods. The visible row-pairs are the lines from index V_FP+V_SYNC through V_FP+V_SYNC+HEIGHT/V_LANES-1.
- R4: Data-enable is high only when the horizontal and vertical positions are both inside their active segments.
- R5: Horizontal sync is high for one cycle per visible row-pair, in the same cycle as the first data-enable beat of that row-pair, and at no other time.
- R6: Vertical sync is high in every cycle of lines V_FP through V_FP+V_SYNC-1, and low in all other cycles.
- R7: While data-enable is high, beat_o gives the 0-based beat index within the line and row_o gives the 0-based row-pair index within the frame. While data-enable is low, both are 0.
- R8: frame_done_o is high for exactly one cycle, in the cycle immediately after the last beat of the last row-pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_o | output | 1 | Data-enable: high on active beats |
| hsync_o | output | 1 | Start-of-row-pair marker |
| vsync_o | output | 1 | Vertical sync, high during the sync lines |
| beat_o | output | BEAT_W | Active beat index within the line |
| row_o | output | ROW_W | Active row-pair index within the frame |
| frame_done_o | output | 1 | One-cycle pulse after the last active beat |

## Verification
Two functions always fall in the same cycle: the rising edge of data-enable at the first beat of a visible row-pair, and the horizontal sync marker. Every cycle of several frames is therefore scored against a position model, so that each row-pair start is judged on both signals together, along with the beat and row indices. A reset asserted in the middle of a frame then checks that the timing restarts cleanly from position 0. Running checks on the intervals between sync pulses, the length of each data-enable run and the spacing between frame-done pulses also confirm the line and frame lengths.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    SEG_FP   = 2'd0,
    SEG_SYNC = 2'd1,
    SEG_ACT  = 2'd2,
    SEG_BP   = 2'd3
  } seg_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vt_axis.sv
module vt_axis
  import vt_pkg::*;
#(
  parameter int FP   = 50,
  parameter int SYNC = 1,
  parameter int ACT  = 192,
  parameter int BP   = 50,
  localparam int TOT = FP + SYNC + ACT + BP,
  localparam int CW  = idx_w(TOT),
  localparam int IW  = idx_w(ACT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic          last_o,
  output seg_e          seg_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [CW-1:0] SYNC_START = CW'(FP);
  localparam logic [CW-1:0] ACT_START  = CW'(FP + SYNC);
  localparam logic [CW-1:0] BP_START   = CW'(FP + SYNC + ACT);
  localparam logic [CW-1:0] CNT_LAST   = CW'(TOT - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_q < SYNC_START)      seg_o = SEG_FP;
    else if (cnt_q < ACT_START)  seg_o = SEG_SYNC;
    else if (cnt_q < BP_START)   seg_o = SEG_ACT;
    else                         seg_o = SEG_BP;
  end

  always_comb begin
    idx_o = '0;
    if (seg_o == SEG_ACT) idx_o = IW'(cnt_q - ACT_START);
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o) |=> (cnt_q == '0));
endmodule

// File: rtl/vt_out_stage.sv
module vt_out_stage
  import vt_pkg::*;
#(
  parameter int H_ACT = 192,
  parameter int V_ACT = 256,
  localparam int BW = idx_w(H_ACT),
  localparam int RW = idx_w(V_ACT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seg_e          h_seg_i,
  input  seg_e          v_seg_i,
  input  logic [BW-1:0] h_idx_i,
  input  logic [RW-1:0] v_idx_i,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic [BW-1:0] beat_o,
  output logic [RW-1:0] row_o,
  output logic          done_o
);
  localparam logic [BW-1:0] BEAT_LAST = BW'(H_ACT - 1);
  localparam logic [RW-1:0] ROW_LAST  = RW'(V_ACT - 1);

  logic de_d;
  assign de_d = (h_seg_i == SEG_ACT) && (v_seg_i == SEG_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o    <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      beat_o  <= '0;
      row_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      de_o    <= de_d;
      hsync_o <= de_d && (h_idx_i == '0);
      vsync_o <= (v_seg_i == SEG_SYNC);
      beat_o  <= de_d ? h_idx_i : '0;
      row_o   <= de_d ? v_idx_i : '0;
      // pulse trails the final beat by one cycle
      done_o  <= de_o && (beat_o == BEAT_LAST) && (row_o == ROW_LAST);
    end
  end

  p_hs_with_de_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> de_o);
  p_hs_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |=> !hsync_o);
  p_vs_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> !de_o);
  p_beat_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && !hsync_o && $past(de_o)) |-> (beat_o == $past(beat_o) + 1'b1));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !de_o);
endmodule

// File: rtl/mlane_vid_timing.sv
module mlane_vid_timing
  import vt_pkg::*;
#(
  parameter int H_FP    = 50,
  parameter int H_SYNC  = 1,
  parameter int H_BP    = 50,
  parameter int WIDTH   = 768,
  parameter int H_LANES = 4,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 1,
  parameter int V_BP    = 10,
  parameter int HEIGHT  = 512,
  parameter int V_LANES = 2,
  localparam int H_ACT  = WIDTH / H_LANES,
  localparam int V_ACT  = HEIGHT / V_LANES,
  localparam int BEAT_W = idx_w(H_ACT),
  localparam int ROW_W  = idx_w(V_ACT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              frame_done_o
);
  seg_e              h_seg, v_seg;
  logic              h_last, v_last;
  logic [BEAT_W-1:0] h_idx;
  logic [ROW_W-1:0]  v_idx;

  vt_axis #(.FP(H_FP), .SYNC(H_SYNC), .ACT(H_ACT), .BP(H_BP)) u_h_axis (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(1'b1),
    .last_o(h_last),
    .seg_o (h_seg),
    .idx_o (h_idx)
  );

  // vertical axis steps once per line, counted in row-pairs
  vt_axis #(.FP(V_FP), .SYNC(V_SYNC), .ACT(V_ACT), .BP(V_BP)) u_v_axis (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(h_last),
    .last_o(v_last),
    .seg_o (v_seg),
    .idx_o (v_idx)
  );

  vt_out_stage #(.H_ACT(H_ACT), .V_ACT(V_ACT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .h_seg_i(h_seg),
    .v_seg_i(v_seg),
    .h_idx_i(h_idx),
    .v_idx_i(v_idx),
    .de_o   (de_o),
    .hsync_o(hsync_o),
    .vsync_o(vsync_o),
    .beat_o (beat_o),
    .row_o  (row_o),
    .done_o (frame_done_o)
  );

  p_frame_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_last && v_last) |=> (h_seg == SEG_FP || H_FP == 0));
  p_de_inside_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> !vsync_o);
endmodule

// File: tb/mlane_vid_timing_test.sv
module mlane_vid_timing_test;
  localparam int HFP = 3, HS = 1, HBP = 2, W = 16, HL = 4;
  localparam int VFP = 2, VS = 1, VBP = 2, H = 6, VL = 2;
  localparam int HA = W / HL;   // 4 beats
  localparam int VA = H / VL;   // 3 row-pairs
  localparam int HT = HFP + HS + HA + HBP;  // 10
  localparam int VT = VFP + VS + VA + VBP;  // 8
  localparam int FT = HT * VT;              // 80

  typedef struct {
    bit de; bit hs; bit vs; int beat; int row; bit done;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic de_o, hsync_o, vsync_o, frame_done_o;
  logic [1:0] beat_o;
  logic [1:0] row_o;

  int n_cmp = 0, n_bad = 0;
  int pos = 0;
  exp_t q[$];

  mlane_vid_timing #(
    .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP), .WIDTH(W), .H_LANES(HL),
    .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .HEIGHT(H), .V_LANES(VL)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .de_o(de_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .beat_o(beat_o), .row_o(row_o),
    .frame_done_o(frame_done_o)
  );

  always #2 clk_i = ~clk_i;  // 250 MHz

  function automatic bit last_pos(input int p);
    int h, v;
    h = p % HT; v = (p / HT) % VT;
    return (h == HFP + HS + HA - 1) && (v == VFP + VS + VA - 1);
  endfunction

  function automatic exp_t model(input int p);
    exp_t e;
    int h, v;
    bit ah, av;
    h = p % HT; v = (p / HT) % VT;
    ah = (h >= HFP + HS) && (h < HFP + HS + HA);
    av = (v >= VFP + VS) && (v < VFP + VS + VA);
    e.de   = ah && av;
    e.hs   = e.de && (h == HFP + HS);
    e.vs   = (v >= VFP) && (v < VFP + VS);
    e.beat = e.de ? h - HFP - HS : 0;
    e.row  = e.de ? v - VFP - VS : 0;
    e.done = (p >= 1) && last_pos(p - 1);
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cycles(input int n);
    repeat (n) begin
      @(posedge clk_i);
      q.push_back(model(pos));
      pos++;
    end
  endtask

  task automatic check_reset_state();
    chk(de_o == 0 && hsync_o == 0 && vsync_o == 0 && frame_done_o == 0,
        "R1 reset flags", {de_o, hsync_o, vsync_o, frame_done_o}, 0);
    chk(beat_o == 0 && row_o == 0, "R1 reset indices", {beat_o, row_o}, 0);
  endtask

  // scoreboard monitor
  int hs_gap = 0, de_run = 0, done_gap = 0;
  bit seen_hs = 0, seen_done = 0;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      hs_gap = 0; de_run = 0; done_gap = 0; seen_hs = 0; seen_done = 0;
    end else if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(de_o == e.de, "R4 de", de_o, e.de);
      chk(hsync_o == e.hs, "R5 hsync", hsync_o, e.hs);
      chk(vsync_o == e.vs, "R6 vsync", vsync_o, e.vs);
      chk(beat_o == e.beat, "R7 beat", beat_o, e.beat);
      chk(row_o == e.row, "R7 row", row_o, e.row);
      chk(frame_done_o == e.done, "R8 frame_done", frame_done_o, e.done);
      hs_gap++; done_gap++;
      if (hsync_o) begin
        if (seen_hs)
          chk(hs_gap == HT || hs_gap == HT * (VT - VA + 1), "R2 hsync spacing",
              hs_gap, HT);
        seen_hs = 1; hs_gap = 0;
      end
      if (de_o) de_run++;
      else if (de_run > 0) begin
        chk(de_run == HA, "R2 de run length", de_run, HA);
        de_run = 0;
      end
      if (frame_done_o) begin
        if (seen_done) chk(done_gap == FT, "R3 frame length", done_gap, FT);
        seen_done = 1; done_gap = 0;
      end
    end
  end

  initial begin
    #1;
    check_reset_state();            // R1 at time zero under reset
    repeat (3) @(negedge clk_i);
    check_reset_state();
    #1 rst_ni = 1'b1;
    pos = 0;
    run_cycles(3 * FT + 37);        // R2 R3: several frames
    @(negedge clk_i);
    #1 rst_ni = 1'b0;               // mid-frame reset
    @(negedge clk_i);
    check_reset_state();            // R1 asynchronous clear
    #1 rst_ni = 1'b1;
    pos = 0;
    run_cycles(2 * FT + 5);
    @(negedge clk_i);
    @(negedge clk_i);
    chk(q.size() == 0, "R1 scoreboard drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule